// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block connects a 16-bit internal bus to an external bus. The external port width is either 8 or 16 bits, and the chip-select decoder reports it for each access on `port_8bit`. A requester presents an address, a size (byte or word), a direction and write data. The block then runs one or two external cycles. For each cycle it drives the external address with its LSB, the address strobe, the per-lane data strobes, the direction and the steered write data. Each external cycle lasts until the external ready input is sampled high.

A word transfer to an 8-bit port is split into two byte cycles that follow each other directly. Both cycles use the upper data lane. The address strobe stays high across both cycles, and the external address LSB is 0 in the first cycle and 1 in the second. Data is big-endian, so the first byte is the more significant one.

Every transfer to a 16-bit port takes one external cycle. On a 16-bit port the byte lane is chosen by the data strobes, and the external address LSB is held at 0. When the last cycle ends, the block raises a completion pulse for one clock and presents the assembled read data.

Top module: `dbs_ctrl`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1, `done` is 0, `rdata` is 0, and the address strobe and both lane strobes are 0.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. From the next clock, `ext_addr_stb` is 1 and `ext_rd` is 1 for a read and 0 for a write. Address, size, direction, write data and `port_8bit` are captured at that edge, so later changes to these inputs have no effect on the transfer.
- R3: An external cycle holds its address, strobes and write data unchanged until a rising edge at which `ext_ready` is 1.
- R4: A word transfer to a 16-bit port takes one cycle. Both lane strobes are 1, the external address LSB is 0 even when `req_addr[0]` is 1, and a read returns `ext_rdata` unchanged.
- R5: A byte transfer to a 16-bit port takes one cycle with the external address LSB at 0. If `req_addr[0]`=0, the upper lane is used (D[15:8], `ext_hi_stb`). If `req_addr[0]`=1, the lower lane is used (D[7:0], `ext_lo_stb`). A write puts `req_wdata[7:0]` on the selected lane and 0 on the other lane. A read returns the selected lane's byte in `rdata[7:0]`, with `rdata[15:8]`=0.
- R6: A word transfer to an 8-bit port runs two byte cycles. `ext_addr_stb` stays 1 from the start of the first cycle to the end of the second. Only `ext_hi_stb` is asserted. The external address LSB is 0 in the first cycle and 1 in the second, and the upper address bits are `req_addr[AW-1:1]`.
- R7: On a split read, D[15:8] from the first cycle goes to `rdata[15:8]` and D[15:8] from the second cycle goes to `rdata[7:0]`.
- R8: On a split write, D[15:8] carries `req_wdata[15:8]` in the first cycle and `req_wdata[7:0]` in the second. D[7:0] is 0 in both cycles.
- R9: A byte transfer to an 8-bit port takes one cycle on the upper lane with the external address LSB equal to `req_addr[0]`. A write drives `req_wdata[7:0]` on D[15:8]. A read returns D[15:8] in `rdata[7:0]`, with `rdata[15:8]`=0.
- R10: `done` is 1 for exactly one clock: the clock after the edge at which the final cycle's ready is sampled. In that same clock `rdata` holds the result, the address strobe is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | AW | Byte address of the transfer |
| req_word | input | 1 | 1 = word (16-bit), 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (a byte write uses bits 7:0) |
| port_8bit | input | 1 | Decoder result: 1 = 8-bit port, 0 = 16-bit port |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read result (a byte read returns it in bits 7:0) |
| ext_addr | output | AW | External address, including the LSB |
| ext_addr_stb | output | 1 | External address strobe |
| ext_hi_stb | output | 1 | Data strobe for lane D[15:8] |
| ext_lo_stb | output | 1 | Data strobe for lane D[7:0] |
| ext_rd | output | 1 | 1 = read cycle, 0 = write cycle |
| ext_wdata | output | 16 | External write data, steered to lanes |
| ext_rdata | input | 16 | External read data |
| ext_ready | input | 1 | External cycle-end handshake |

## Verification
The completion pulse of one transfer and the acceptance of the next request can land in the same clock. The bench provokes this by issuing every transfer directly after the previous one, so a new request is raised in the clock where `done` is high. In that clock it checks that `req_ready` is 1 and that the scoreboard pops the result of the earlier transfer. On the following clocks it checks that the new transfer's first cycle starts with its own address, strobes and captured port width, not the inverted values left on the inputs after the request was taken.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    localparam int LANE_W = 8;
    localparam int BUS_W  = 2 * LANE_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT0 = 2'd1,
        ST_BEAT1 = 2'd2
    } dbs_state_e;

    typedef struct packed {
        logic             word;
        logic             write;
        logic             port8;
        logic             a0;
        logic [BUS_W-1:0] wdata;
    } dbs_req_t;

    // Word to a narrow port needs two byte beats.
    function automatic logic is_split(dbs_req_t r);
        return r.word & r.port8;
    endfunction

    // Lane strobes as {upper, lower}.
    function automatic logic [1:0] lane_strobes(dbs_req_t r);
        if (r.port8)
            return 2'b10;
        else if (r.word)
            return 2'b11;
        else
            return r.a0 ? 2'b01 : 2'b10;
    endfunction

    // External address LSB for a given beat.
    function automatic logic beat_a0(dbs_req_t r, logic beat);
        if (r.port8)
            return r.word ? beat : r.a0;
        return 1'b0;
    endfunction

    // Write data placed on the lanes for a given beat.
    function automatic logic [BUS_W-1:0] steer_wdata(dbs_req_t r, logic beat);
        logic [LANE_W-1:0] zb;
        zb = '0;
        if (!r.write)
            return '0;
        if (r.port8) begin
            if (r.word)
                return {(beat ? r.wdata[LANE_W-1:0] : r.wdata[BUS_W-1:LANE_W]), zb};
            return {r.wdata[LANE_W-1:0], zb};
        end
        if (r.word)
            return r.wdata;
        return r.a0 ? {zb, r.wdata[LANE_W-1:0]} : {r.wdata[LANE_W-1:0], zb};
    endfunction

    // Byte lane a single-byte read is taken from.
    function automatic logic [LANE_W-1:0] pick_lane(dbs_req_t r, logic [BUS_W-1:0] d);
        return (r.port8 || !r.a0) ? d[BUS_W-1:LANE_W] : d[LANE_W-1:0];
    endfunction

endpackage

// File: rtl/dbs_seq.sv
module dbs_seq
    import dbs_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [AW-1:0]        req_addr,
    input  logic                 req_word,
    input  logic                 req_write,
    input  logic [BUS_W-1:0]     req_wdata,
    input  logic                 port_8bit,
    input  logic                 ext_ready,
    output dbs_state_e           state,
    output dbs_req_t             cur,
    output logic [AW-2:0]        cur_hi,
    output logic                 beat,
    output logic                 beat_done,
    output logic                 req_ready,
    output logic                 done
);

    dbs_state_e nxt;
    logic       last_end;

    always_comb begin
        req_ready = (state == ST_IDLE);
        beat      = (state == ST_BEAT1);
        beat_done = (state != ST_IDLE) && ext_ready;
        last_end  = beat_done && (beat || !is_split(cur));
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) nxt = ST_BEAT0;
            ST_BEAT0: if (ext_ready) nxt = is_split(cur) ? ST_BEAT1 : ST_IDLE;
            ST_BEAT1: if (ext_ready) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cur    <= '0;
            cur_hi <= '0;
            done   <= 1'b0;
        end else begin
            state <= nxt;
            done  <= last_end;
            if (req_valid && req_ready) begin
                cur.word  <= req_word;
                cur.write <= req_write;
                cur.port8 <= port_8bit;
                cur.a0    <= req_word ? 1'b0 : req_addr[0];
                cur.wdata <= req_wdata;
                cur_hi    <= req_addr[AW-1:1];
            end
        end
    end

    assert_hold_beat_R3: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && !ext_ready) |=> (state == $past(state)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_ready_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(ext_ready) && ($past(state) != ST_IDLE)));

    assert_second_beat_split_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BEAT1) |-> is_split(cur));

endmodule

// File: rtl/dbs_bus_drive.sv
module dbs_bus_drive
    import dbs_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  dbs_state_e           state,
    input  dbs_req_t             cur,
    input  logic [AW-2:0]        cur_hi,
    input  logic                 beat,
    input  logic                 ext_ready,
    output logic [AW-1:0]        ext_addr,
    output logic                 ext_addr_stb,
    output logic                 ext_hi_stb,
    output logic                 ext_lo_stb,
    output logic                 ext_rd,
    output logic [BUS_W-1:0]     ext_wdata
);

    logic active;

    always_comb begin
        active       = (state != ST_IDLE);
        ext_addr_stb = active;
        {ext_hi_stb, ext_lo_stb} = active ? lane_strobes(cur) : 2'b00;
        ext_addr     = active ? {cur_hi, beat_a0(cur, beat)} : '0;
        ext_rd       = active && !cur.write;
        ext_wdata    = active ? steer_wdata(cur, beat) : '0;
    end

    assert_strobe_span_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BEAT0 && is_split(cur) && ext_ready)
        |=> (ext_addr_stb && ext_hi_stb && ext_addr[0]));

    assert_narrow_upper_only_R9: assert property (@(posedge clk) disable iff (rst)
        (ext_addr_stb && cur.port8) |-> !ext_lo_stb);

    assert_wide_a0_low_R4: assert property (@(posedge clk) disable iff (rst)
        (ext_addr_stb && !cur.port8) |-> !ext_addr[0]);

    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (ext_addr_stb && !ext_ready) |=> ($stable(ext_addr) && $stable(ext_wdata)));

endmodule

// File: rtl/dbs_rd_asm.sv
module dbs_rd_asm
    import dbs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  dbs_req_t             cur,
    input  logic                 beat,
    input  logic                 beat_done,
    input  logic [BUS_W-1:0]     ext_rdata,
    output logic [BUS_W-1:0]     rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (beat_done && !cur.write) begin
            if (is_split(cur)) begin
                if (!beat)
                    rdata[BUS_W-1:LANE_W] <= ext_rdata[BUS_W-1:LANE_W];
                else
                    rdata[LANE_W-1:0]     <= ext_rdata[BUS_W-1:LANE_W];
            end else if (cur.word) begin
                rdata <= ext_rdata;
            end else begin
                rdata <= {{LANE_W{1'b0}}, pick_lane(cur, ext_rdata)};
            end
        end
    end

    assert_low_byte_second_R7: assert property (@(posedge clk) disable iff (rst)
        (beat_done && beat && !cur.write)
        |=> (rdata[LANE_W-1:0] == $past(ext_rdata[BUS_W-1:LANE_W])));

    assert_high_byte_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (beat_done && beat && !cur.write)
        |=> (rdata[BUS_W-1:LANE_W] == $past(rdata[BUS_W-1:LANE_W])));

endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
    import dbs_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_word,
    input  logic              req_write,
    input  logic [15:0]       req_wdata,
    input  logic              port_8bit,
    output logic              done,
    output logic [15:0]       rdata,
    output logic [AW-1:0]     ext_addr,
    output logic              ext_addr_stb,
    output logic              ext_hi_stb,
    output logic              ext_lo_stb,
    output logic              ext_rd,
    output logic [15:0]       ext_wdata,
    input  logic [15:0]       ext_rdata,
    input  logic              ext_ready
);

    dbs_state_e     state;
    dbs_req_t       cur;
    logic [AW-2:0]  cur_hi;
    logic           beat;
    logic           beat_done;

    dbs_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_word  (req_word),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .port_8bit (port_8bit),
        .ext_ready (ext_ready),
        .state     (state),
        .cur       (cur),
        .cur_hi    (cur_hi),
        .beat      (beat),
        .beat_done (beat_done),
        .req_ready (req_ready),
        .done      (done)
    );

    dbs_bus_drive #(.AW(AW)) u_drive (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .cur          (cur),
        .cur_hi       (cur_hi),
        .beat         (beat),
        .ext_ready    (ext_ready),
        .ext_addr     (ext_addr),
        .ext_addr_stb (ext_addr_stb),
        .ext_hi_stb   (ext_hi_stb),
        .ext_lo_stb   (ext_lo_stb),
        .ext_rd       (ext_rd),
        .ext_wdata    (ext_wdata)
    );

    dbs_rd_asm u_rd (
        .clk       (clk),
        .rst       (rst),
        .cur       (cur),
        .beat      (beat),
        .beat_done (beat_done),
        .ext_rdata (ext_rdata),
        .rdata     (rdata)
    );

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (req_ready && !ext_addr_stb));

endmodule

// File: tb/tb_dbs_ctrl.sv
`timescale 1ns/1ps
module tb_dbs_ctrl;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic          req_word;
    logic          req_write;
    logic [15:0]   req_wdata;
    logic          port_8bit;
    logic          done;
    logic [15:0]   rdata;
    logic [AW-1:0] ext_addr;
    logic          ext_addr_stb;
    logic          ext_hi_stb;
    logic          ext_lo_stb;
    logic          ext_rd;
    logic [15:0]   ext_wdata;
    logic [15:0]   ext_rdata;
    logic          ext_ready;

    int checks = 0;
    int fails  = 0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    dbs_ctrl #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_word(req_word), .req_write(req_write),
        .req_wdata(req_wdata), .port_8bit(port_8bit), .done(done), .rdata(rdata),
        .ext_addr(ext_addr), .ext_addr_stb(ext_addr_stb), .ext_hi_stb(ext_hi_stb),
        .ext_lo_stb(ext_lo_stb), .ext_rd(ext_rd), .ext_wdata(ext_wdata),
        .ext_rdata(ext_rdata), .ext_ready(ext_ready)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each completion pulse.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R10 completion without transfer: actual 1 expected 0");
            end else begin
                logic [16:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e[16]) chk(t, "read result", {16'h0, rdata}, {16'h0, e[15:0]});
                else       chk("R10", "write completion", 32'd1, 32'd1);
            end
        end
    end

    // Driver: called at a falling edge; acts as requester and external slave.
    task automatic xfer(input logic [AW-1:0] a, input bit word, input bit wr,
                        input bit p8, input logic [15:0] wd,
                        input logic [15:0] r0, input logic [15:0] r1,
                        input int waits, input string tag);
        int          nb;
        logic [15:0] exp_rd;
        nb = (word && p8) ? 2 : 1;
        if (p8 && word)  exp_rd = {r0[15:8], r1[15:8]};
        else if (p8)     exp_rd = {8'h00, r0[15:8]};
        else if (word)   exp_rd = r0;
        else             exp_rd = a[0] ? {8'h00, r0[7:0]} : {8'h00, r0[15:8]};
        exp_q.push_back({~wr, exp_rd});
        tag_q.push_back(tag);

        chk("R2", "req_ready before request", {31'h0, req_ready}, 32'd1);
        req_valid = 1'b1; req_addr = a; req_word = word; req_write = wr;
        req_wdata = wd;   port_8bit = p8;
        @(negedge clk);
        req_valid = 1'b0; port_8bit = ~p8; req_wdata = ~wd; req_addr = ~a;
        req_word = ~word;
        chk("R10", "done low in first beat", {31'h0, done}, 32'd0);

        for (int b = 0; b < nb; b++) begin
            for (int w = 0; w <= waits; w++) begin
                logic [AW-1:0] ea;
                logic [1:0]    es;
                logic [15:0]   ew;
                ea = {a[AW-1:1], (p8 ? (word ? b[0] : a[0]) : 1'b0)};
                if (p8)        es = 2'b10;
                else if (word) es = 2'b11;
                else           es = a[0] ? 2'b01 : 2'b10;
                if (!wr)             ew = 16'h0;
                else if (p8 && word) ew = {(b == 1 ? wd[7:0] : wd[15:8]), 8'h00};
                else if (p8)         ew = {wd[7:0], 8'h00};
                else if (word)       ew = wd;
                else                 ew = a[0] ? {8'h00, wd[7:0]} : {wd[7:0], 8'h00};
                chk("R3", "address strobe held", {31'h0, ext_addr_stb}, 32'd1);
                chk(tag, "external address", {8'h0, ext_addr}, {8'h0, ea});
                chk(tag, "lane strobes", {30'h0, ext_hi_stb, ext_lo_stb}, {30'h0, es});
                chk(tag, "lane write data", {16'h0, ext_wdata}, {16'h0, ew});
                chk("R2", "direction", {31'h0, ext_rd}, {31'h0, ~wr});
                if (w == waits) begin
                    ext_rdata = (b == 1) ? r1 : r0;
                    ext_ready = 1'b1;
                end else begin
                    ext_rdata = 16'hDEAD;
                end
                @(negedge clk);
                ext_ready = 1'b0;
                ext_rdata = 16'hDEAD;
            end
        end
        chk("R10", "done pulse after final ready", {31'h0, done}, 32'd1);
        chk("R10", "strobe released at done", {31'h0, ext_addr_stb}, 32'd0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R3 watchdog: actual no completion expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_word = 1'b0;
        req_write = 1'b0; req_wdata = '0; port_8bit = 1'b0;
        ext_rdata = 16'h0; ext_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "req_ready", {31'h0, req_ready}, 32'd1);
        chk("R1", "done", {31'h0, done}, 32'd0);
        chk("R1", "rdata", {16'h0, rdata}, 32'd0);
        chk("R1", "strobes", {29'h0, ext_addr_stb, ext_hi_stb, ext_lo_stb}, 32'd0);

        xfer(24'h001234, 1, 0, 0, 16'h0000, 16'hA55A, 16'h0000, 0, "R4");
        xfer(24'h000101, 1, 1, 0, 16'hBEEF, 16'h0000, 16'h0000, 2, "R4");
        xfer(24'h000200, 0, 0, 0, 16'h0000, 16'h3C7E, 16'h0000, 0, "R5");
        xfer(24'h000201, 0, 0, 0, 16'h0000, 16'h3C7E, 16'h0000, 1, "R5");
        xfer(24'h000201, 0, 1, 0, 16'h12AB, 16'h0000, 16'h0000, 0, "R5");
        xfer(24'h000400, 1, 0, 1, 16'h0000, 16'hC3FF, 16'h5A00, 1, "R7");
        xfer(24'h000402, 1, 1, 1, 16'hD00F, 16'h0000, 16'h0000, 0, "R8");
        xfer(24'h000403, 0, 0, 1, 16'h0000, 16'h9600, 16'h0000, 0, "R9");
        xfer(24'h000404, 0, 1, 1, 16'h00E1, 16'h0000, 16'h0000, 2, "R9");
        xfer(24'hABCDE1, 1, 0, 1, 16'h0000, 16'h7711, 16'h88EE, 3, "R6");
        xfer(24'h000010, 1, 0, 0, 16'h0000, 16'h0F0F, 16'h0000, 0, "R4");

        @(negedge clk);
        chk("R10", "done single clock", {31'h0, done}, 32'd0);
        chk("R10", "scoreboard drained", exp_q.size(), 32'd0);
        summary();
        $finish;
    end

endmodule